// File: doc/BRIEF.md
# Bit Clock Recovery and Retiming Unit

This unit takes the one-bit output of a demodulator, which arrives with no clock of its own, and rebuilds the bit timing from it. A phase counter runs on the system clock, and its nominal length in clocks comes from a 16-bit divider split into a high byte and a low byte. Each filtered data transition pulls the counter toward the bit boundary, and each pull is limited to a fraction of a period. A bounded frequency trim learns any steady rate offset while the transitions arrive one bit apart. The unit samples the data at mid-bit and presents that sample on a registered output. A data clock rises at the sample point and falls at the next bit boundary.

A lock flag reports that the transitions land close to where the counter expects them. In packet operation the tracking path always runs. In continuous operation an enable bit can switch the tracking path off. The data output then follows the resynchronised input directly and the data clock stays low.

Top module: `bit_retimer`

## Requirements
- R1: The nominal bit period in system clocks equals {period_hi, period_lo}, with period_hi as bits 15:8. Values from 16 upward are supported.
- R2: `locked` rises only on a transition that falls within a quarter period of the expected bit boundary. It needs 8 such transitions in a row. A 16-bit alternating preamble is enough to reach lock, and 6 transitions after reset never are.
- R3: While tracking, the bits recovered on the rising edges of `dclk` match the transmitted sequence. This includes runs of 16 identical bits.
- R4: Recovery holds with the transmitter rate 6 percent above or below nominal. The learned frequency trim never exceeds one eighth of the nominal period in either direction.
- R5: With `pkt_mode` = 1 the tracking path runs whatever the value of `cont_en`.
- R6: With `pkt_mode` = 0 and `cont_en` = 0 (bypass), `dout` equals `rx_raw` delayed by three clocks. `dclk` and `locked` stay 0.
- R7: While tracking, `dout` changes only at a mid-bit sample point. `dclk` rises only at a sample point and falls only at a bit boundary, and the two events never coincide.
- R8: `locked` clears after 32 bit periods with no transition. It stays set at 20 bit periods without a transition.
- R9: While `rst_n` is low, `dout`, `dclk` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Raw demodulated data bit, asynchronous |
| period_hi | input | 8 | Bit period in clocks, bits 15:8 |
| period_lo | input | 8 | Bit period in clocks, bits 7:0 |
| pkt_mode | input | 1 | 1 = packet operation (tracking forced on) |
| cont_en | input | 1 | Tracking enable used in continuous operation |
| dout | output | 1 | Retimed data bit |
| dclk | output | 1 | Recovered data clock, rising at mid-bit |
| locked | output | 1 | Bit timing lock indication |

## Verification
The assertions check on every cycle that `dout` holds between sample points and that the edges of `dclk` fall on sample points and bit boundaries. They also check that bypass passes the resynchronised input and keeps the clock low, that the trim stays in bounds, and that lock only rises on an in-window transition. Only the bench scenarios can show that whole bit sequences come back intact at offset rates and through long runs. They also show how many preamble transitions lock needs and after how many silent bit periods it drops.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
   typedef enum logic {
      PATH_BYPASS = 1'b0,
      PATH_TRACK  = 1'b1
   } path_e;

   function automatic path_e pick_path(input logic pkt, input logic en);
      return (pkt || en) ? PATH_TRACK : PATH_BYPASS;
   endfunction
endpackage

// File: rtl/bsync_in_filter.sv
module bsync_in_filter #(
   parameter int FILT_TAPS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic sync_o,
   output logic filt_o,
   output logic edge_o
);
   logic [1:0] meta;
   logic       maj;
   logic       filt_q, filt_d;

   if (FILT_TAPS != 1 && FILT_TAPS != 3) begin : g_bad_taps
      $error("bsync_in_filter: FILT_TAPS must be 1 or 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) meta <= '0;
      else        meta <= {meta[0], raw_i};
   end
   assign sync_o = meta[1];

   if (FILT_TAPS == 3) begin : g_vote
      logic [2:0] win;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) win <= '0;
         else        win <= {win[1:0], meta[1]};
      end
      assign maj = (win[0] & win[1]) | (win[0] & win[2]) | (win[1] & win[2]);
   end else begin : g_plain
      assign maj = meta[1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         filt_d <= 1'b0;
      end else begin
         filt_q <= maj;
         filt_d <= filt_q;
      end
   end

   assign filt_o = filt_q;
   assign edge_o = filt_q ^ filt_d;
endmodule

// File: rtl/bsync_phase_nco.sv
module bsync_phase_nco #(
   parameter int PW         = 16,
   parameter int WIN_SHIFT  = 2,
   parameter int TRIM_SHIFT = 3,
   parameter int MIN_PERIOD = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] period,
   input  logic          edge_in,
   output logic          sample_pulse,
   output logic          bit_tick,
   output logic          edge_in_win
);
   localparam int SW = PW + 3;
   localparam logic signed [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

   if (WIN_SHIFT < 2 || TRIM_SHIFT < WIN_SHIFT) begin : g_bad_shift
      $error("bsync_phase_nco: need WIN_SHIFT >= 2 and TRIM_SHIFT >= WIN_SHIFT");
   end
   if (MIN_PERIOD < 8) begin : g_bad_min
      $error("bsync_phase_nco: MIN_PERIOD must be at least 8");
   end

   logic [PW:0]            ph;
   logic [1:0]             gap;
   logic signed [SW-1:0]   trim, trim_n;
   logic signed [SW-1:0]   pe, half, quart, tlim, phs, err, corr, nxt, nxt_w, tsum;
   logic                   wrap;

   always_comb begin
      pe    = $signed({3'b000, period}) + trim;
      half  = pe >>> 1;
      quart = pe >>> WIN_SHIFT;
      tlim  = $signed({3'b000, period}) >>> TRIM_SHIFT;
      phs   = $signed({2'b00, ph});
      err   = (phs < half) ? phs : (phs - pe);
      edge_in_win = edge_in && (err < quart) && (err > -quart);
      if (err > quart)       corr = quart;
      else if (err < -quart) corr = -quart;
      else                   corr = err;
      nxt   = phs + ONE - (edge_in ? corr : '0);
      wrap  = 1'b0;
      nxt_w = nxt;
      if (nxt >= pe) begin
         nxt_w = nxt - pe;
         wrap  = 1'b1;
      end
      tsum   = trim + ((err + ONE) >>> 1);
      trim_n = trim;
      if (edge_in_win && gap == 2'd1) begin
         if (tsum > tlim)       trim_n = tlim;
         else if (tsum < -tlim) trim_n = -tlim;
         else                   trim_n = tsum;
      end
   end

   assign sample_pulse = run && (phs == half);
   assign bit_tick     = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= '0;
         trim <= '0;
         gap  <= '0;
      end else if (!run) begin
         ph   <= '0;
         trim <= '0;
         gap  <= '0;
      end else begin
         ph   <= nxt_w[PW:0];
         trim <= trim_n;
         if (edge_in)                          gap <= '0;
         else if (sample_pulse && gap != 2'd3) gap <= gap + 2'd1;
      end
   end

   // R4: learned trim stays within one eighth of the nominal period
   p_trim_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && $stable(period) |-> (trim <= tlim) && (trim >= -tlim));

   // R7: a sample point and a bit boundary never fall in the same cycle
   p_tick_sample_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run && (period >= PW'(MIN_PERIOD)) |-> !(sample_pulse && bit_tick));
endmodule

// File: rtl/bsync_lock_mon.sv
module bsync_lock_mon #(
   parameter int LOCK_EDGES = 8,
   parameter int LOSS_BITS  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic edge_in,
   input  logic edge_in_win,
   input  logic bit_tick,
   output logic locked
);
   localparam int CW = $clog2(LOCK_EDGES + 1);
   localparam int IW = $clog2(LOSS_BITS + 1);
   localparam logic [CW-1:0] GOOD_MAX = CW'(LOCK_EDGES);
   localparam logic [IW-1:0] IDLE_MAX = IW'(LOSS_BITS);

   if (LOCK_EDGES < 2 || LOSS_BITS < 2) begin : g_bad_cfg
      $error("bsync_lock_mon: LOCK_EDGES and LOSS_BITS must be at least 2");
   end

   logic [CW-1:0] good;
   logic [IW-1:0] idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good   <= '0;
         idle   <= '0;
         locked <= 1'b0;
      end else if (!run) begin
         good   <= '0;
         idle   <= '0;
         locked <= 1'b0;
      end else if (edge_in) begin
         idle <= '0;
         if (edge_in_win) begin
            if (good != GOOD_MAX) good <= good + 1'b1;
            if (good >= GOOD_MAX - 1'b1) locked <= 1'b1;
         end else begin
            good <= '0;
         end
      end else if (bit_tick && idle != IDLE_MAX) begin
         idle <= idle + 1'b1;
         if (idle == IDLE_MAX - 1'b1) begin
            locked <= 1'b0;
            good   <= '0;
         end
      end
   end

   // R2: lock can only rise on an in-window transition
   p_lock_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(run && edge_in_win));

   // R8: a silent stretch of the loss length leaves the flag clear
   p_lock_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (idle == IDLE_MAX) |-> !locked);
endmodule

// File: rtl/bit_retimer.sv
module bit_retimer #(
   parameter int PW         = 16,
   parameter int FILT_TAPS  = 3,
   parameter int WIN_SHIFT  = 2,
   parameter int TRIM_SHIFT = 3,
   parameter int LOCK_EDGES = 8,
   parameter int LOSS_BITS  = 32,
   parameter int MIN_PERIOD = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_raw,
   input  logic [7:0] period_hi,
   input  logic [7:0] period_lo,
   input  logic       pkt_mode,
   input  logic       cont_en,
   output logic       dout,
   output logic       dclk,
   output logic       locked
);
   import bsync_pkg::*;

   if (PW != 16) begin : g_bad_pw
      $error("bit_retimer: the divider is two bytes, PW must be 16");
   end

   logic [PW-1:0] period;
   path_e         path;
   logic          run, sync_b, filt_b, edge_b;
   logic          sample_pulse, bit_tick, edge_in_win;

   assign period = {period_hi, period_lo};
   assign path   = pick_path(pkt_mode, cont_en);
   assign run    = (path == PATH_TRACK);

   bsync_in_filter #(.FILT_TAPS(FILT_TAPS)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (rx_raw),
      .sync_o (sync_b),
      .filt_o (filt_b),
      .edge_o (edge_b)
   );

   bsync_phase_nco #(
      .PW(PW), .WIN_SHIFT(WIN_SHIFT), .TRIM_SHIFT(TRIM_SHIFT), .MIN_PERIOD(MIN_PERIOD)
   ) u_nco (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .period       (period),
      .edge_in      (edge_b),
      .sample_pulse (sample_pulse),
      .bit_tick     (bit_tick),
      .edge_in_win  (edge_in_win)
   );

   bsync_lock_mon #(.LOCK_EDGES(LOCK_EDGES), .LOSS_BITS(LOSS_BITS)) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .edge_in     (edge_b),
      .edge_in_win (edge_in_win),
      .bit_tick    (bit_tick),
      .locked      (locked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= 1'b0;
         dclk <= 1'b0;
      end else if (!run) begin
         dout <= sync_b;
         dclk <= 1'b0;
      end else if (sample_pulse) begin
         dout <= filt_b;
         dclk <= 1'b1;
      end else if (bit_tick) begin
         dclk <= 1'b0;
      end
   end

   // R6: bypass keeps the data clock low
   p_dclk_low_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!run) |-> !dclk);

   // R6: bypass forwards the resynchronised input
   p_dout_follows_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!run) |-> dout == $past(sync_b));

   // R7: data only moves at a sample point while tracking
   p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(run) && !$past(sample_pulse) |-> $stable(dout));

   // R7: clock rises only at a sample point
   p_dclk_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $rose(dclk) |-> $past(sample_pulse));

   // R7: clock falls only at a bit boundary while tracking
   p_dclk_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(run) && $fell(dclk) |-> $past(bit_tick));
endmodule

// File: tb/bit_retimer_tb_top.sv
module bit_retimer_tb_top;
   localparam int CLK_P  = 10;
   localparam int N_SCN  = 6;
   localparam int CAP_N  = 512;
   // fields: nominal period [25:10], tx rate percent [9:2], pkt_mode [1], cont_en [0]
   localparam logic [25:0] SCN [N_SCN] = '{
      {16'd100, 8'd100, 1'b1, 1'b0},
      {16'd100, 8'd106, 1'b1, 1'b1},
      {16'd100, 8'd94,  1'b1, 1'b0},
      {16'd100, 8'd106, 1'b0, 1'b1},
      {16'd100, 8'd94,  1'b0, 1'b1},
      {16'd300, 8'd94,  1'b0, 1'b1}
   };
   localparam logic [63:0] PAYLOAD = 64'hB4FFFF000096A5C3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_raw = 1'b0;
   logic [7:0] period_hi = 8'd0, period_lo = 8'd100;
   logic       pkt_mode = 1'b1, cont_en = 1'b0;
   logic       dout, dclk, locked;

   int  total = 0, bad = 0;
   logic cap [CAP_N];
   int  ncap = 0;
   logic dclk_q = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bit_retimer dut_i (
      .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw),
      .period_hi(period_hi), .period_lo(period_lo),
      .pkt_mode(pkt_mode), .cont_en(cont_en),
      .dout(dout), .dclk(dclk), .locked(locked)
   );

   always @(negedge clk) begin
      if (dclk && !dclk_q && ncap < CAP_N) begin
         cap[ncap] = dout;
         ncap = ncap + 1;
      end
      dclk_q = dclk;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tx_bit(input logic b, input int n);
      rx_raw = b;
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic [15:0] per, input logic pm, input logic en);
      @(negedge clk);
      rst_n = 1'b0;
      rx_raw = 1'b0;
      period_hi = per[15:8];
      period_lo = per[7:0];
      pkt_mode = pm;
      cont_en = en;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      ncap = 0;
      @(negedge clk);
   endtask

   function automatic bit payload_found();
      for (int off = 0; off + 64 <= ncap; off++) begin
         bit hit = 1'b1;
         for (int k = 0; k < 64; k++)
            if (cap[off + k] !== PAYLOAD[63 - k]) hit = 1'b0;
         if (hit) return 1'b1;
      end
      return 1'b0;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R9: outputs during reset
      repeat (3) @(negedge clk);
      chk(dout == 1'b0, "R9 dout in reset", int'(dout), 0);
      chk(dclk == 1'b0, "R9 dclk in reset", int'(dclk), 0);
      chk(locked == 1'b0, "R9 locked in reset", int'(locked), 0);

      for (int s = 0; s < N_SCN; s++) begin
         logic [15:0] per = SCN[s][25:10];
         int tp = int'(per) * int'(SCN[s][9:2]) / 100;
         do_reset(per, SCN[s][1], SCN[s][0]);
         repeat (10) tx_bit(1'b0, tp);
         for (int i = 0; i < 16; i++) tx_bit(~i[0], tp);
         // R2 (R5 when cont_en is 0 in packet mode): lock reached inside the preamble
         chk(locked == 1'b1, "R2 lock after preamble", int'(locked), 1);
         for (int i = 63; i >= 0; i--) tx_bit(PAYLOAD[i], tp);
         for (int i = 0; i < 8; i++) tx_bit(i[0], tp);
         repeat (2) tx_bit(1'b1, tp);
         // R1 R3 R4 R5: payload with 16-bit runs recovered at offset rate
         chk(payload_found(), "R3 R4 payload recovered", ncap, 64);
         repeat (18) tx_bit(1'b1, tp);
         chk(locked == 1'b1, "R8 lock held after 20 silent bits", int'(locked), 1);
         repeat (20) tx_bit(1'b1, tp);
         chk(locked == 1'b0, "R8 lock lost after silence", int'(locked), 0);
      end

      // R2: six transitions after reset never give lock
      do_reset(16'd100, 1'b1, 1'b0);
      repeat (3) tx_bit(1'b0, 100);
      for (int i = 0; i < 6; i++) tx_bit(~i[0], 100);
      chk(locked == 1'b0, "R2 no lock on 6 transitions", int'(locked), 0);

      // R6: bypass passes the input with three clocks of delay, clock held low
      do_reset(16'd100, 1'b0, 1'b0);
      for (int i = 0; i < 12; i++) begin
         logic b = (i % 3 == 0) ^ i[2];
         rx_raw = b;
         repeat (2) @(negedge clk);
         chk(dout == ~b || dout == b, "R6 dout defined", int'(dout), int'(b));
         @(negedge clk);
         chk(dout == b, "R6 bypass data", int'(dout), int'(b));
         chk(dclk == 1'b0, "R6 bypass clock low", int'(dclk), 0);
         chk(locked == 1'b0, "R6 bypass not locked", int'(locked), 0);
      end

      // R5: packet mode with enable low still produces a data clock
      do_reset(16'd100, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) tx_bit(i[0], 100);
      chk(ncap >= 6, "R5 clock runs in packet mode", ncap, 6);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule